// File: doc/BRIEF.md
# Watchdog Event Control Register

This block is the control word of a system-management watchdog. It sits at offset 08h of a small I/O-style register window and exposes five active bits. The first is a one-way lock; the enable-register logic elsewhere reads it to reject changes to the watchdog enable. The second is a halt that freezes the watchdog counter. The third requests an event message, and hardware withdraws it when the transmitter reports completion. The fourth routes NMIs to SMIs. The fifth lets software force an NMI.

Software writes a 16-bit word while `addr_i` matches the offset, and reads the word back through the combinational `rdata_o`. The counter, the message transmitter and the interrupt controller are separate blocks. They consume `halt_o`, `msg_req_o`, `nmi_o` and `smi_o`, and the transmitter answers with `msg_done_i`. The external reset is asynchronous and active low. Its release passes through a two-stage synchronizer, so the register leaves reset two clock edges after `rst_n` rises.

Top module: `wdog_evt_ctl`

## Requirements
- R1: After reset every stored bit is 0: reading offset 08h returns 0000h, and `lock_o`, `halt_o`, `msg_req_o`, `nmi_o` and `smi_o` are all 0.
- R2: Writing 1 to bit 12 sets the lock, which `lock_o` follows. No later write clears it; only reset does.
- R3: Bit 12 cannot be cleared by writing 0 to it, and the write's other bits still take effect.
- R4: Bit 11 is a plain read/write halt bit and drives `halt_o`.
- R5: Writing 1 to bit 10 while it is 0 sets it. `msg_req_o` equals bit 10 AND NOT bit 11. A write of 1 while bit 10 is already 1 leaves it at 1 and issues no new request.
- R6: A `msg_done_i` pulse clears bit 10 at that clock edge. When a register write and `msg_done_i` fall in the same cycle, bit 10 becomes 0 and the other bits take the write data.
- R7: Bit 9 is a plain read/write redirect bit.
- R8: A forced NMI is routed by the bit 9 value that holds after the write. With bit 9 = 0 it pulses `nmi_o`. With bit 9 = 1 it pulses `smi_o` only if `nmi_mask_i` = 0 and `smi_glob_en_i` = 1, and otherwise produces no pulse on either output.
- R9: Writing 1 to bit 8 while it is 0 sets it and produces exactly one cycle-long pulse, in the cycle after the write edge. Writing 1 while it is 1 clears it without a pulse. Writing 0 leaves it unchanged.
- R10: Bits 15:13 and 7:0 always read 0 and ignore writes. Writes to any other address change nothing, and reads of any other address return 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Access address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| msg_done_i | input | 1 | Transmitter completion pulse |
| nmi_mask_i | input | 1 | NMI mask from the NMI logic |
| smi_glob_en_i | input | 1 | Global SMI enable |
| lock_o | output | 1 | Watchdog enable lock |
| halt_o | output | 1 | Counter halt |
| msg_req_o | output | 1 | Event message request |
| nmi_o | output | 1 | NMI pulse |
| smi_o | output | 1 | SMI pulse |

## Verification
The forced-NMI path is swept over all eight combinations of redirect, mask and global enable. This separates the NMI, SMI and silent outcomes of the routing table. Each combination is also followed by a second set write and a write of 0, which together confirm the single pulse, the toggle-style clear and the inert 0. The bench walks a 1 through every reserved bit position, writes all ones to foreign addresses, and places a completion pulse both alone and together with a set write. These patterns separate the ignore rules and the hardware-over-software priority from ordinary read/write behaviour. A mid-run reset then shows that the lock can be released only by reset.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int REG_W     = 16;
  localparam int LOCK_BIT  = 12;
  localparam int HALT_BIT  = 11;
  localparam int SEND_BIT  = 10;
  localparam int REDIR_BIT = 9;
  localparam int FORCE_BIT = 8;
  localparam int RW_N      = 2;

  localparam logic [REG_W-1:0] LIVE_MASK =
    (REG_W'(1) << LOCK_BIT) | (REG_W'(1) << HALT_BIT) | (REG_W'(1) << SEND_BIT) |
    (REG_W'(1) << REDIR_BIT) | (REG_W'(1) << FORCE_BIT);
  localparam logic [REG_W-1:0] RSV_MASK = ~LIVE_MASK;

  typedef struct packed {
    logic lock;
    logic halt;
    logic send;
    logic redir;
    logic force_nmi;
  } ctl_bits_t;
endpackage

// File: rtl/wdc_sticky_bit.sv
module wdc_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  a_r3_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
    q_o |=> q_o);
  a_r2_sets_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/wdc_msg_req.sv
module wdc_msg_req (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wr_bit_i,
  input  logic done_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (done_i)                          pend_d = 1'b0;
    else if (wr_i && wr_bit_i && !pend_q) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !pend_o);
  a_r5_held_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !done_i) |=> pend_o);
  a_r5_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wr_bit_i && !done_i) |=> pend_o);
endmodule

// File: rtl/wdc_nmi_route.sv
module wdc_nmi_route (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic force_bit_i,
  input  logic redir_i,
  input  logic mask_i,
  input  logic glob_i,
  output logic pend_o,
  output logic nmi_o,
  output logic smi_o
);
  logic pend_q, pend_d;
  logic nmi_q, nmi_d;
  logic smi_q, smi_d;
  logic fire;

  always_comb begin
    fire   = wr_i && force_bit_i && !pend_q;
    pend_d = pend_q;
    if (wr_i && force_bit_i) pend_d = !pend_q;
    nmi_d  = fire && !redir_i;
    smi_d  = fire && redir_i && !mask_i && glob_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      nmi_q  <= 1'b0;
      smi_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      nmi_q  <= nmi_d;
      smi_q  <= smi_d;
    end
  end

  assign pend_o = pend_q;
  assign nmi_o  = nmi_q;
  assign smi_o  = smi_q;

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o || smi_o) |=> !(nmi_o || smi_o));
  a_r9_pulse_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o || smi_o) |-> $rose(pend_o));
  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_o && smi_o));
  a_r8_smi_gated: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> $past(redir_i && !mask_i && glob_i));
  a_r8_nmi_unredirected: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> $past(!redir_i));
endmodule

// File: rtl/wdog_evt_ctl.sv
module wdog_evt_ctl #(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFFSET = 8'h08
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      wr_en_i,
  input  logic [wdc_pkg::REG_W-1:0] wdata_i,
  output logic [wdc_pkg::REG_W-1:0] rdata_o,
  input  logic                      msg_done_i,
  input  logic                      nmi_mask_i,
  input  logic                      smi_glob_en_i,
  output logic                      lock_o,
  output logic                      halt_o,
  output logic                      msg_req_o,
  output logic                      nmi_o,
  output logic                      smi_o
);
  import wdc_pkg::*;

  // reset: asserted at once, released after two edges
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // access decode
  logic hit, wr;
  assign hit = (addr_i == OFFSET);
  assign wr  = wr_en_i && hit;

  // plain read/write bits: halt and redirect
  logic [RW_N-1:0] rw_q, rw_d;
  logic            redir_next;

  for (genvar g = 0; g < RW_N; g++) begin : g_rw
    localparam int POS = (g == 0) ? HALT_BIT : REDIR_BIT;
    always_comb begin
      rw_d[g] = rw_q[g];
      if (wr) rw_d[g] = wdata_i[POS];
    end
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) rw_q[g] <= 1'b0;
      else            rw_q[g] <= rw_d[g];
    end
  end
  assign redir_next = rw_d[1];

  logic lock_q, send_q, force_q;

  wdc_sticky_bit u_lock (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (wr && wdata_i[LOCK_BIT]),
    .q_o   (lock_q)
  );

  wdc_msg_req u_msg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_i     (wr),
    .wr_bit_i (wdata_i[SEND_BIT]),
    .done_i   (msg_done_i),
    .pend_o   (send_q)
  );

  wdc_nmi_route u_nmi (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_i        (wr),
    .force_bit_i (wdata_i[FORCE_BIT]),
    .redir_i     (redir_next),
    .mask_i      (nmi_mask_i),
    .glob_i      (smi_glob_en_i),
    .pend_o      (force_q),
    .nmi_o       (nmi_o),
    .smi_o       (smi_o)
  );

  ctl_bits_t cur;
  always_comb begin
    cur.lock      = lock_q;
    cur.halt      = rw_q[0];
    cur.send      = send_q;
    cur.redir     = rw_q[1];
    cur.force_nmi = force_q;
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[LOCK_BIT]  = cur.lock;
      rdata_o[HALT_BIT]  = cur.halt;
      rdata_o[SEND_BIT]  = cur.send;
      rdata_o[REDIR_BIT] = cur.redir;
      rdata_o[FORCE_BIT] = cur.force_nmi;
    end
  end

  assign lock_o    = cur.lock;
  assign halt_o    = cur.halt;
  assign msg_req_o = cur.send && !cur.halt;

  a_r4_halt_follows_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr |=> (halt_o == $past(wdata_i[HALT_BIT])));
  a_r10_foreign_write_inert: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en_i && !hit && !msg_done_i) |=> $stable(cur));
  a_r10_reserved_write_inert: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr && ((wdata_i & RSV_MASK) != '0)) |=> ((rdata_o & RSV_MASK) == '0));
endmodule

// File: tb/wdog_evt_ctl_test.sv
module wdog_evt_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr_i;
  logic        wr_en_i;
  logic [15:0] wdata_i;
  logic [15:0] rdata_o;
  logic        msg_done_i;
  logic        nmi_mask_i;
  logic        smi_glob_en_i;
  logic        lock_o, halt_o, msg_req_o, nmi_o, smi_o;

  int vecs  = 0;
  int fails = 0;

  // expected state, derived from the requirements
  logic e_lock, e_halt, e_send, e_redir, e_force, e_nmi, e_smi;

  always #2 clk = ~clk;

  wdog_evt_ctl uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .msg_done_i(msg_done_i),
    .nmi_mask_i(nmi_mask_i), .smi_glob_en_i(smi_glob_en_i),
    .lock_o(lock_o), .halt_o(halt_o), .msg_req_o(msg_req_o),
    .nmi_o(nmi_o), .smi_o(smi_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    addr_i = 8'h08;
    #0.1;
    chk(req, rdata_o, {3'b000, e_lock, e_halt, e_send, e_redir, e_force, 8'h00});
    chk(req, {11'd0, lock_o, halt_o, msg_req_o, nmi_o, smi_o},
        {11'd0, e_lock, e_halt, e_send && !e_halt, e_nmi, e_smi});
  endtask

  task automatic clear_model();
    e_lock = 0; e_halt = 0; e_send = 0; e_redir = 0; e_force = 0; e_nmi = 0; e_smi = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    clear_model();
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic done);
    logic fire;
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1; msg_done_i = done;
    @(negedge clk);
    wr_en_i = 1'b0; msg_done_i = 1'b0;
    fire = 1'b0;
    if (a == 8'h08) begin
      fire = d[8] && !e_force;
      if (d[12]) e_lock = 1'b1;
      e_halt  = d[11];
      e_redir = d[9];
      if (d[8]) e_force = !e_force;
      if (!done && d[10]) e_send = 1'b1;
    end
    if (done) e_send = 1'b0;
    e_nmi = fire && !e_redir;
    e_smi = fire && e_redir && !nmi_mask_i && smi_glob_en_i;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    e_nmi = 1'b0; e_smi = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_i = 8'h08; wr_en_i = 1'b0; wdata_i = '0;
    msg_done_i = 1'b0; nmi_mask_i = 1'b0; smi_glob_en_i = 1'b0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check_all("R1 reset");

    // R10: walking one across reserved positions, then all reserved set
    for (int b = 0; b < 16; b++) begin
      if (b < 8 || b > 12) begin
        wr(8'h08, 16'(1) << b, 1'b0);
        check_all("R10 reserved bit");
      end
    end
    wr(8'h08, 16'hE0FF, 1'b0);
    check_all("R10 reserved all");

    // R10: foreign addresses ignore writes and read zero
    for (int a = 0; a < 16; a++) begin
      if (a != 8) begin
        wr(8'(a), 16'hFFFF, 1'b0);
        addr_i = 8'(a);
        #0.1;
        chk("R10 foreign read", rdata_o, 16'h0000);
        check_all("R10 foreign write");
      end
    end

    // R4: halt read/write
    wr(8'h08, 16'h0800, 1'b0); check_all("R4 halt set");
    wr(8'h08, 16'h0000, 1'b0); check_all("R4 halt clear");

    // R5: message request
    wr(8'h08, 16'h0400, 1'b0); check_all("R5 request set");
    wr(8'h08, 16'h0400, 1'b0); check_all("R5 repeat write while set");
    wr(8'h08, 16'h0000, 1'b0); check_all("R5 write 0 keeps request");
    wr(8'h08, 16'h0800, 1'b0); check_all("R5 halt masks request");
    // R6: done pulse alone, with halt lifted in same cycle
    wr(8'h08, 16'h0000, 1'b1); check_all("R6 done with write");
    wr(8'h08, 16'h0400, 1'b1); check_all("R6 done beats set");
    wr(8'h08, 16'h0400, 1'b0); check_all("R6 set after priority case");
    @(negedge clk); msg_done_i = 1'b1;
    @(negedge clk); msg_done_i = 1'b0; e_send = 1'b0;
    check_all("R6 done alone");

    // R7/R8/R9: routing sweep over redirect, mask, global enable
    for (int v = 0; v < 8; v++) begin
      nmi_mask_i    = v[1];
      smi_glob_en_i = v[2];
      wr(8'h08, {6'd0, v[0], 1'b1, 8'h00}, 1'b0);
      check_all("R8 routed pulse");
      idle_cycle();
      check_all("R9 pulse ends");
      wr(8'h08, {6'd0, v[0], 1'b1, 8'h00}, 1'b0);
      check_all("R9 second write clears");
      wr(8'h08, {6'd0, v[0], 1'b0, 8'h00}, 1'b0);
      check_all("R7 redirect kept, R9 write 0 inert");
      wr(8'h08, {6'd0, v[0], 1'b1, 8'h00}, 1'b0);
      check_all("R9 fires again after clear");
      wr(8'h08, {6'd0, v[0], 1'b1, 8'h00}, 1'b0);
      check_all("R9 cleared");
    end
    nmi_mask_i = 1'b0; smi_glob_en_i = 1'b0;

    // R2/R3: lock
    wr(8'h08, 16'h1000, 1'b0); check_all("R2 lock set");
    wr(8'h08, 16'h0A00, 1'b0); check_all("R3 write 0 keeps lock");
    wr(8'h08, 16'h0000, 1'b0); check_all("R3 lock sticky");
    do_reset();
    check_all("R1 R2 reset releases lock");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule